// File: doc/BRIEF.md
# Message-Signaled Interrupt Generator

This block converts per-vector interrupt events from the surrounding logic into posted memory-write requests on a simple bus-master request/response pair. When message signaling is enabled, each serviced event becomes one write. In single-message mode that write uses one shared address register and one shared data register. In table mode it uses the vector's own address/data entry. When message signaling is disabled, the block instead drives a level-sensitive legacy interrupt pin.

Each vector is one-shot. An event captured on an armed vector makes it pending and disarms it, and software must re-arm it before it can signal again. A mask bit per vector holds a pending vector back, and the vector is sent as soon as its mask is cleared. A round-robin arbiter picks among the unmasked pending vectors. Only one request is outstanding at a time. A request whose termination is anything but a normal completion is dropped for one cycle and then reissued unchanged.

The control state machine has three states. `ST_IDLE` waits for a grant and moves to `ST_BUSY` when message signaling is enabled and some vector is eligible. `ST_BUSY` holds the request: a completion goes to `ST_IDLE`, and a retry or either abort goes to `ST_BACKOFF`. `ST_BACKOFF` always returns to `ST_BUSY` on the next cycle.

Top module: `msg_irq_gen`

## Requirements
- R1: In single-message mode (control bit1 = 0, bit0 = 1), an event on vector 0 produces a request whose address is the single address register and whose data is the single data register.
- R2: While control bit0 (message enable) is 0, no new request starts. The legacy pin is high while any active, unmasked vector is pending. A re-arm write for that vector clears its pending state and drops the pin.
- R3: In table mode (control bit1 = 1), a request for vector v carries table address entry v and table data entry v.
- R4: An event on a masked, armed vector makes it pending without producing a request. The request is issued after the mask bit is cleared.
- R5: After a vector has captured an event, further events on it are ignored until a re-arm write sets its bit.
- R6: Response codes are 0 for completion, 1 for retry, 2 for master-abort and 3 for target-abort. On codes 1 to 3 the request drops for exactly one cycle and is then reasserted with the same address and data. Only code 0 retires the vector.
- R7: Once raised, the request stays high with a stable address and data until a response arrives.
- R8: While messages are enabled, the configuration-error output is high if any address in use is bad. The addresses in use are the single address in single-message mode, or every unmasked table entry in table mode. An address is bad if bits 31:20 differ from 0xFEE or bit 3 (the redirection hint) is set.
- R9: After reset the control register is 0, all vectors are armed, vector 0 is unmasked and all other vectors are masked, and all outputs are low.
- R10: Eligible vectors are granted in round-robin order, starting from the vector after the one granted last. The first grant after reset goes to the lowest eligible vector.
- R11: In single-message mode, events on vectors other than 0 are ignored.
- R12: Only host writes change the registers. The cfg_kind codes are 0 control, 1 single address, 2 single data, 3 table address[idx], 4 table data[idx], 5 mask vector, and 6 re-arm (each set bit re-arms that vector).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_i | input | NVEC | Per-vector event pulses |
| cfg_we_i | input | 1 | Host register write strobe |
| cfg_kind_i | input | 3 | Register selector (R12 codes) |
| cfg_idx_i | input | IW | Table entry index |
| cfg_wdata_i | input | 32 | Host write data |
| req_o | output | 1 | Memory-write request |
| req_addr_o | output | AW | Write target address |
| req_data_o | output | DW | Write payload |
| rsp_valid_i | input | 1 | Termination reported this cycle |
| rsp_code_i | input | 2 | Termination code (R6) |
| legacy_irq_o | output | 1 | Level interrupt pin used when messages are off |
| cfg_err_o | output | 1 | Address in use lies outside the window |

## Verification
The bench sends each retry and abort code and checks the one-cycle gap and the unchanged reissue. A design that retired the vector on an abort would lose the interrupt, and one that skipped the gap or changed the address would be caught at the reissue. It raises an event on a vector that is still masked from reset and expects nothing until the mask clears. A design that dropped the event instead of holding it pending would never send it. It repeats events without re-arming, and fires three vectors at once to check the rotating grant order. It also switches messages off and checks that the legacy pin rises and that no write is issued.

// File: rtl/msg_irq_pkg.sv
package msg_irq_pkg;
    typedef enum logic [2:0] {
        K_CTRL  = 3'd0,
        K_SADDR = 3'd1,
        K_SDATA = 3'd2,
        K_TADDR = 3'd3,
        K_TDATA = 3'd4,
        K_MASK  = 3'd5,
        K_REARM = 3'd6
    } cfg_kind_e;

    typedef enum logic [1:0] {
        RSP_DONE  = 2'd0,
        RSP_RETRY = 2'd1,
        RSP_MABT  = 2'd2,
        RSP_TABT  = 2'd3
    } rsp_e;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_BUSY    = 2'd1,
        ST_BACKOFF = 2'd2
    } st_e;

    localparam logic [11:0] WIN_HI   = 12'hFEE;
    localparam int          HINT_BIT = 3;
endpackage

// File: rtl/msg_irq_regs.sv
module msg_irq_regs
    import msg_irq_pkg::*;
#(
    parameter int NVEC = 4,
    parameter int AW   = 32,
    parameter int DW   = 32,
    localparam int IW  = (NVEC > 1) ? $clog2(NVEC) : 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cfg_we,
    input  logic [2:0]               cfg_kind,
    input  logic [IW-1:0]            cfg_idx,
    input  logic [31:0]              cfg_wdata,
    output logic                     msg_en,
    output logic                     tbl_mode,
    output logic [AW-1:0]            saddr,
    output logic [DW-1:0]            sdata,
    output logic [NVEC-1:0][AW-1:0]  taddr,
    output logic [NVEC-1:0][DW-1:0]  tdata,
    output logic [NVEC-1:0]          mask,
    output logic [NVEC-1:0]          rearm,
    output logic                     cfg_err
);
    localparam logic [AW-1:0] ADDR_RST = {WIN_HI, {(AW-12){1'b0}}};

    logic [NVEC-1:0] bad_vec;

    function automatic logic bad_addr(input logic [AW-1:0] a);
        return (a[AW-1 -: 12] != WIN_HI) || a[HINT_BIT];
    endfunction

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            msg_en   <= 1'b0;
            tbl_mode <= 1'b0;
            saddr    <= ADDR_RST;
            sdata    <= '0;
            taddr    <= {NVEC{ADDR_RST}};
            tdata    <= '0;
            mask     <= {{(NVEC-1){1'b1}}, 1'b0};
        end else if (cfg_we) begin
            unique case (cfg_kind_e'(cfg_kind))
                K_CTRL:  begin msg_en <= cfg_wdata[0]; tbl_mode <= cfg_wdata[1]; end
                K_SADDR: saddr <= cfg_wdata[AW-1:0];
                K_SDATA: sdata <= cfg_wdata[DW-1:0];
                K_TADDR: taddr[cfg_idx] <= cfg_wdata[AW-1:0];
                K_TDATA: tdata[cfg_idx] <= cfg_wdata[DW-1:0];
                K_MASK:  mask <= cfg_wdata[NVEC-1:0];
                default: ;
            endcase
        end
    end

    assign rearm = (cfg_we && cfg_kind == K_REARM) ? cfg_wdata[NVEC-1:0] : '0;

    for (genvar v = 0; v < NVEC; v++) begin : g_chk
        assign bad_vec[v] = bad_addr(taddr[v]);
    end

    assign cfg_err = msg_en && (tbl_mode ? |(bad_vec & ~mask) : bad_addr(saddr));

    // R12
    ctrl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_we |=> $stable(msg_en) && $stable(tbl_mode) && $stable(mask));
endmodule

// File: rtl/msg_irq_rr.sv
module msg_irq_rr #(
    parameter int N   = 4,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N-1:0]  req,
    input  logic          take,
    output logic          grant_vld,
    output logic [IW-1:0] grant_idx
);
    logic [IW-1:0] last_q;

    always_comb begin
        grant_vld = 1'b0;
        grant_idx = last_q;
        for (int k = 1; k <= N; k++) begin
            int j;
            j = (int'(last_q) + k) % N;
            if (!grant_vld && req[j]) begin
                grant_vld = 1'b1;
                grant_idx = IW'(j);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)              last_q <= IW'(N-1);
        else if (take && grant_vld) last_q <= grant_idx;
    end

    // R10
    grant_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
        grant_vld |-> req[grant_idx]);
endmodule

// File: rtl/msg_irq_gen.sv
module msg_irq_gen
    import msg_irq_pkg::*;
#(
    parameter int NVEC = 4,
    parameter int AW   = 32,
    parameter int DW   = 32,
    localparam int IW  = (NVEC > 1) ? $clog2(NVEC) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NVEC-1:0] evt_i,
    input  logic            cfg_we_i,
    input  logic [2:0]      cfg_kind_i,
    input  logic [IW-1:0]   cfg_idx_i,
    input  logic [31:0]     cfg_wdata_i,
    output logic            req_o,
    output logic [AW-1:0]   req_addr_o,
    output logic [DW-1:0]   req_data_o,
    input  logic            rsp_valid_i,
    input  logic [1:0]      rsp_code_i,
    output logic            legacy_irq_o,
    output logic            cfg_err_o
);
    logic                    msg_en, tbl_mode;
    logic [AW-1:0]           saddr;
    logic [DW-1:0]           sdata;
    logic [NVEC-1:0][AW-1:0] taddr;
    logic [NVEC-1:0][DW-1:0] tdata;
    logic [NVEC-1:0]         mask, rearm, active, elig, pend_q, armed_q;
    logic                    grant_vld, take, done;
    logic [IW-1:0]           grant_idx, cur_q;
    st_e                     state_q, state_d;

    msg_irq_regs #(.NVEC(NVEC), .AW(AW), .DW(DW)) u_regs (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we_i), .cfg_kind(cfg_kind_i),
        .cfg_idx(cfg_idx_i), .cfg_wdata(cfg_wdata_i), .msg_en(msg_en),
        .tbl_mode(tbl_mode), .saddr(saddr), .sdata(sdata), .taddr(taddr),
        .tdata(tdata), .mask(mask), .rearm(rearm), .cfg_err(cfg_err_o)
    );

    assign active = tbl_mode ? {NVEC{1'b1}} : {{(NVEC-1){1'b0}}, 1'b1};
    assign elig   = pend_q & ~mask & active;
    assign take   = (state_q == ST_IDLE) && msg_en && grant_vld;
    assign done   = (state_q == ST_BUSY) && rsp_valid_i && (rsp_e'(rsp_code_i) == RSP_DONE);

    msg_irq_rr #(.N(NVEC)) u_arb (
        .clk(clk), .rst_n(rst_n), .req(msg_en ? elig : '0), .take(take),
        .grant_vld(grant_vld), .grant_idx(grant_idx)
    );

    // per-vector one-shot and pending state
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q  <= '0;
            armed_q <= '1;
        end else begin
            for (int v = 0; v < NVEC; v++) begin
                if (rearm[v]) begin
                    armed_q[v] <= 1'b1;
                    if (!msg_en) pend_q[v] <= 1'b0;
                end
                if (done && cur_q == IW'(v)) pend_q[v] <= 1'b0;
                if (evt_i[v] && armed_q[v] && active[v]) begin
                    pend_q[v]  <= 1'b1;
                    armed_q[v] <= 1'b0;
                end
            end
        end
    end

    // request payload captured at grant
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q      <= '0;
            req_addr_o <= '0;
            req_data_o <= '0;
        end else if (take) begin
            cur_q      <= grant_idx;
            req_addr_o <= tbl_mode ? taddr[grant_idx] : saddr;
            req_data_o <= tbl_mode ? tdata[grant_idx] : sdata;
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (take) state_d = ST_BUSY;
            ST_BUSY:    if (rsp_valid_i) state_d = done ? ST_IDLE : ST_BACKOFF;
            ST_BACKOFF: state_d = ST_BUSY;
            default:    state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        req_o        = (state_q == ST_BUSY);
        legacy_irq_o = !msg_en && |(pend_q & ~mask & active);
    end

    // R7
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_o && !rsp_valid_i |=> req_o && $stable(req_addr_o) && $stable(req_data_o));

    // R2
    legacy_no_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) && !msg_en |=> !req_o);

    // R6
    retry_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_o && rsp_valid_i && rsp_code_i != 2'd0 |=> !req_o ##1 (req_o && req_addr_o == $past(req_addr_o, 2)));
endmodule

// File: tb/msg_irq_gen_tb.sv
`timescale 1ns/1ps
module msg_irq_gen_tb;
    localparam int NVEC = 4;
    localparam int IW   = 2;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [NVEC-1:0] evt_i = '0;
    logic            cfg_we_i = 1'b0;
    logic [2:0]      cfg_kind_i = '0;
    logic [IW-1:0]   cfg_idx_i = '0;
    logic [31:0]     cfg_wdata_i = '0;
    logic            req_o, legacy_irq_o, cfg_err_o;
    logic [31:0]     req_addr_o, req_data_o;
    logic            rsp_valid_i = 1'b0;
    logic [1:0]      rsp_code_i = '0;

    int n_chk = 0, n_fail = 0;
    bit finished = 1'b0;

    // rows: {vector[3:2], response code[1:0]}
    localparam logic [3:0] ROWS [5] = '{4'b00_00, 4'b10_01, 4'b11_10, 4'b01_11, 4'b10_00};

    always #5 clk = ~clk;

    msg_irq_gen #(.NVEC(NVEC)) u_dut (
        .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .cfg_we_i(cfg_we_i),
        .cfg_kind_i(cfg_kind_i), .cfg_idx_i(cfg_idx_i), .cfg_wdata_i(cfg_wdata_i),
        .req_o(req_o), .req_addr_o(req_addr_o), .req_data_o(req_data_o),
        .rsp_valid_i(rsp_valid_i), .rsp_code_i(rsp_code_i),
        .legacy_irq_o(legacy_irq_o), .cfg_err_o(cfg_err_o)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic hw(input logic [2:0] kind, input int idx, input logic [31:0] d);
        cfg_we_i = 1'b1; cfg_kind_i = kind; cfg_idx_i = IW'(idx); cfg_wdata_i = d;
        @(negedge clk);
        cfg_we_i = 1'b0;
    endtask

    task automatic pulse(input logic [NVEC-1:0] v);
        evt_i = v;
        @(negedge clk);
        evt_i = '0;
    endtask

    task automatic respond(input logic [1:0] code);
        rsp_valid_i = 1'b1; rsp_code_i = code;
        @(negedge clk);
        rsp_valid_i = 1'b0;
    endtask

    task automatic wait_req(output bit got);
        got = 1'b0;
        for (int i = 0; i < 10 && !got; i++) begin
            if (req_o) got = 1'b1;
            else @(negedge clk);
        end
    endtask

    task automatic expect_msg(input string tag, input logic [31:0] a, input logic [31:0] d, input logic [1:0] code);
        bit got;
        wait_req(got);
        chk(got, tag, 32'(got), 32'd1);
        chk(req_addr_o == a, tag, req_addr_o, a);
        chk(req_data_o == d, tag, req_data_o, d);
        respond(code);
        if (code != 2'd0) begin
            chk(!req_o, {tag, " R6 gap"}, 32'(req_o), 32'd0);
            @(negedge clk);
            chk(req_o, {tag, " R6 reissue"}, 32'(req_o), 32'd1);
            chk(req_addr_o == a && req_data_o == d, {tag, " R6 same payload"}, req_addr_o, a);
            respond(2'd0);
        end
    endtask

    task automatic expect_none(input string tag, input int n);
        bit seen = 1'b0;
        for (int i = 0; i < n; i++) begin
            if (req_o) seen = 1'b1;
            @(negedge clk);
        end
        chk(!seen, tag, 32'(seen), 32'd0);
    endtask

    initial begin
        #(200000 * 10);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R9 reset state
        chk(!req_o && !legacy_irq_o && !cfg_err_o, "R9 outputs low after reset",
            {29'd0, req_o, legacy_irq_o, cfg_err_o}, 32'd0);

        // R2 legacy mode: message enable is 0 after reset
        pulse(4'b0001);
        chk(legacy_irq_o, "R2 legacy pin raised", 32'(legacy_irq_o), 32'd1);
        expect_none("R2 no write while disabled", 4);
        hw(3'd6, 0, 32'h1);
        chk(!legacy_irq_o, "R2 re-arm drops legacy pin", 32'(legacy_irq_o), 32'd0);

        // R1 single-message mode, R9 vector 0 unmasked by default
        hw(3'd1, 0, 32'hFEE0_1000);
        hw(3'd2, 0, 32'h0000_0041);
        hw(3'd0, 0, 32'h1);
        pulse(4'b0001);
        expect_msg("R1 R9 single message", 32'hFEE0_1000, 32'h41, 2'd0);
        // R11 other vectors ignored in single mode
        pulse(4'b0010);
        expect_none("R11 vector 1 ignored in single mode", 5);
        // R5 one-shot without re-arm
        pulse(4'b0001);
        expect_none("R5 repeat without re-arm", 5);
        hw(3'd6, 0, 32'h1);
        pulse(4'b0001);
        expect_msg("R5 signal after re-arm", 32'hFEE0_1000, 32'h41, 2'd0);
        hw(3'd6, 0, 32'h1);

        // R8 address window checks
        hw(3'd1, 0, 32'hFEF0_0000);
        chk(cfg_err_o, "R8 outside window", 32'(cfg_err_o), 32'd1);
        hw(3'd1, 0, 32'hFEE0_0008);
        chk(cfg_err_o, "R8 redirection hint set", 32'(cfg_err_o), 32'd1);
        hw(3'd1, 0, 32'hFEE0_1000);
        chk(!cfg_err_o, "R8 valid address", 32'(cfg_err_o), 32'd0);

        // R3 table mode programming
        for (int v = 0; v < NVEC; v++) begin
            hw(3'd3, v, 32'hFEE0_0000 | (v << 12));
            hw(3'd4, v, 32'h100 + v);
        end
        hw(3'd0, 0, 32'h3);
        // R9 R4 vector 1 masked from reset: held pending
        pulse(4'b0010);
        expect_none("R9 R4 masked vector silent", 5);
        hw(3'd5, 0, 32'h0);
        expect_msg("R4 pending sent on unmask", 32'hFEE0_1000, 32'h101, 2'd0);
        hw(3'd6, 0, 32'h2);

        // R3 R6 table walk
        for (int r = 0; r < 5; r++) begin
            automatic int v = int'(ROWS[r][3:2]);
            pulse(NVEC'(1) << v);
            expect_msg($sformatf("R3 row %0d", r), 32'hFEE0_0000 | (v << 12), 32'h100 + v, ROWS[r][1:0]);
            hw(3'd6, 0, 32'h1 << v);
        end

        // R10 round robin: last grant was vector 2, expect 3, 0, 1
        pulse(4'b1011);
        expect_msg("R10 first grant v3", 32'hFEE0_3000, 32'h103, 2'd0);
        expect_msg("R10 second grant v0", 32'hFEE0_0000, 32'h100, 2'd0);
        expect_msg("R10 third grant v1", 32'hFEE0_1000, 32'h101, 2'd0);
        hw(3'd6, 0, 32'hF);

        // R12 only host writes alter state: mask a vector, event stays silent
        hw(3'd5, 0, 32'h8);
        pulse(4'b1000);
        expect_none("R12 R4 mask kept", 5);

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule